// File: doc/BRIEF.md
# Serial Multi-Port LED Status Shifter

This block turns the link, speed, duplex, collision and activity status of a group of ports into a serial bit stream on two wires, a clock and a data line. A plain external shift register clocks data in on each rising edge of the clock, and its outputs drive the LEDs directly. After the last bit of a frame the clock stays high for a fixed idle time, and then the next frame begins. All LED levels are active low.

A two-bit format code is latched while reset is held, and it chooses how many bits each port uses and how they are encoded. Activity and collision indications blink, and a select input picks a fast or a slow blink rate. A strap that is also latched at reset can enable a lamp test after reset, during which every LED blinks together.

Top module: `led_serial_shifter`

## Requirements
- R1: `led_data` changes only in the cycle in which `led_clk` falls, so each bit is stable across the rising edge that captures it. Between frames `led_clk` stays high for `GAP_CYC` cycles.
- R2: A frame sends port 0 first and port NPORT-1 last. In format 00 each port sends 3 bits, first collision/duplex, then link/activity, then speed, for 3*NPORT bits in all.
- R3: In format 01 each port sends 2 bits, first speed, then link/activity, for 2*NPORT bits in all.
- R4: In format 10 (bi-color) each port sends 3 bits in the same order as format 00. The second bit is lit only for a 10 Mb/s link (`speed`=0). The third bit is lit only for a 100 Mb/s link (`speed`=1). Activity blinks both of them.
- R5: Format 11 behaves exactly like format 00.
- R6: Every bit is active low (0 = lit). Link/activity is lit when `link` is 1, and it goes dark during the off phase of the blink while `act` is 1. Speed (formats 00, 01 and 11) is lit when `speed` is 1. Collision/duplex is lit when `duplex` is 1, unless `coll` is 1, in which case it blinks.
- R7: The blink toggles every `BLINK_FAST_HALF` cycles when `blink_sel` is 1 (a 43 ms period) and every `BLINK_SLOW_HALF` cycles when it is 0 (a 120 ms period).
- R8: `fmt_strap` and `no_test_strap` are sampled only while `rst_n` is low. A change after reset has no effect on the frame length or on the encoding.
- R9: With `no_test_strap`=0, for `TEST_CYC` cycles after reset every bit of a frame carries the same blink level, and that level alternates from frame to frame. After this time normal status is sent. With `no_test_strap`=1 there is no lamp test.
- R10: While reset is held, `led_clk` and `led_data` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the straps are sampled while it is low |
| fmt_strap | input | 2 | Output format code (00, 01, 10 bi-color, 11 same as 00) |
| no_test_strap | input | 1 | 1 skips the lamp test after reset |
| blink_sel | input | 1 | 1 selects the fast blink, 0 the slow blink |
| link | input | NPORT | Link up per port |
| speed | input | NPORT | 1 = 100 Mb/s per port |
| duplex | input | NPORT | 1 = full duplex per port |
| coll | input | NPORT | Collision seen per port |
| act | input | NPORT | Activity per port |
| led_clk | output | 1 | Serial clock to the external shift register |
| led_data | output | 1 | Serial data, captured on the rising edge of `led_clk` |

## Verification
The in-module assertions check on every cycle that data moves only on a falling clock, that the clock stays high through the idle gap, that the bit index stays within the frame for the latched format, and that each bit of a lamp-test frame carries that frame's common level. Some behaviour shows only in the bench's scenarios. These are the bit order and encoding for each format, the active-low levels, the frame lengths, the two blink rates measured across many frames, the end of the lamp test, and the fact that strap changes after reset are ignored.

// File: rtl/led_serial_shifter.sv
module led_serial_shifter #(
  parameter int NPORT           = 8,
  parameter int CLK_DIV         = 4,
  parameter int GAP_CYC         = 2500,
  parameter int BLINK_FAST_HALF = 537500,
  parameter int BLINK_SLOW_HALF = 1500000,
  parameter int TEST_CYC        = 25000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt_strap,
  input  logic             no_test_strap,
  input  logic             blink_sel,
  input  logic [NPORT-1:0] link,
  input  logic [NPORT-1:0] speed,
  input  logic [NPORT-1:0] duplex,
  input  logic [NPORT-1:0] coll,
  input  logic [NPORT-1:0] act,
  output logic             led_clk,
  output logic             led_data
);
  localparam int FW    = 3 * NPORT;
  localparam int IW    = $clog2(FW);
  localparam int CMAX  = (GAP_CYC > 2 * CLK_DIV) ? GAP_CYC : 2 * CLK_DIV;
  localparam int CW    = $clog2(CMAX + 1);
  localparam int BMAX  = (BLINK_SLOW_HALF > BLINK_FAST_HALF) ? BLINK_SLOW_HALF : BLINK_FAST_HALF;
  localparam int BW    = $clog2(BMAX + 1);
  localparam int TW    = $clog2(TEST_CYC + 1);

  logic [1:0] fmt_q;
  logic       skip_test_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q       <= fmt_strap;
      skip_test_q <= no_test_strap;
    end
  end

  wire two_bit = (fmt_q == 2'b01);
  wire bicolor = (fmt_q == 2'b10);
  wire [IW-1:0] last_bit = two_bit ? IW'(2 * NPORT - 1) : IW'(3 * NPORT - 1);

  logic [BW-1:0] bcnt;
  logic          blink_ph;
  wire  [BW-1:0] half = blink_sel ? BW'(BLINK_FAST_HALF - 1) : BW'(BLINK_SLOW_HALF - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt     <= '0;
      blink_ph <= 1'b0;
    end else if (bcnt >= half) begin
      bcnt     <= '0;
      blink_ph <= ~blink_ph;
    end else begin
      bcnt <= bcnt + 1'b1;
    end
  end

  logic [TW-1:0] tcnt;
  logic          test_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt      <= '0;
      test_done <= 1'b0;
    end else if (!test_done) begin
      if (tcnt == TW'(TEST_CYC - 1)) test_done <= 1'b1;
      else                           tcnt      <= tcnt + 1'b1;
    end
  end

  wire lamp_test = !skip_test_q && !test_done;

  logic [FW-1:0] fvec;

  always_comb begin
    fvec = '1;
    for (int p = 0; p < NPORT; p++) begin
      logic on_la, on_cf;
      on_la = link[p] & ~(act[p] & blink_ph);
      on_cf = coll[p] ? ~blink_ph : duplex[p];
      if (two_bit) begin
        fvec[2*p]   = ~speed[p];
        fvec[2*p+1] = ~on_la;
      end else begin
        fvec[3*p] = ~on_cf;
        if (bicolor) begin
          fvec[3*p+1] = ~(on_la & ~speed[p]);
          fvec[3*p+2] = ~(on_la &  speed[p]);
        end else begin
          fvec[3*p+1] = ~on_la;
          fvec[3*p+2] = ~speed[p];
        end
      end
    end
    if (lamp_test) fvec = {FW{blink_ph}};
  end

  logic          in_gap;
  logic [CW-1:0] cnt;
  logic [IW-1:0] bit_idx;
  logic [FW-1:0] sreg;
  logic          clk_q, data_q;
  logic          frame_lamp_q, frame_lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_gap       <= 1'b1;
      cnt          <= '0;
      bit_idx      <= '0;
      sreg         <= '1;
      clk_q        <= 1'b1;
      data_q       <= 1'b1;
      frame_lamp_q <= 1'b0;
      frame_lvl_q  <= 1'b0;
    end else if (in_gap) begin
      if (cnt == CW'(GAP_CYC - 1)) begin
        cnt          <= '0;
        in_gap       <= 1'b0;
        bit_idx      <= '0;
        sreg         <= fvec >> 1;
        data_q       <= fvec[0];
        clk_q        <= 1'b0;
        frame_lamp_q <= lamp_test;
        frame_lvl_q  <= blink_ph;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == CW'(CLK_DIV - 1)) clk_q <= 1'b1;
      if (cnt == CW'(2 * CLK_DIV - 1)) begin
        cnt <= '0;
        if (bit_idx == last_bit) begin
          in_gap <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          clk_q   <= 1'b0;
          data_q  <= sreg[0];
          sreg    <= sreg >> 1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign led_clk  = clk_q;
  assign led_data = data_q;

  // R1
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led_data) |-> $fell(led_clk));

  // R1
  gap_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_gap && $past(in_gap)) |-> led_clk);

  // R3
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_gap |-> (bit_idx <= last_bit));

  // R9
  lamp_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_gap && frame_lamp_q) |-> (led_data == frame_lvl_q));

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (led_clk && led_data));
endmodule

// File: tb/led_serial_shifter_tb_top.sv
module led_serial_shifter_tb_top;
  localparam int NP = 8;
  localparam int CD = 2;
  localparam int GAP = 20;
  localparam int FH = 350;
  localparam int SH = 1000;
  localparam int TC = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic ntest = 1'b1, bsel = 1'b1;
  logic [NP-1:0] link = '0, spd = '0, dup = '0, col = '0, act = '0;
  logic led_clk, led_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  led_serial_shifter #(.NPORT(NP), .CLK_DIV(CD), .GAP_CYC(GAP), .BLINK_FAST_HALF(FH),
    .BLINK_SLOW_HALF(SH), .TEST_CYC(TC)) dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_strap(fmt), .no_test_strap(ntest), .blink_sel(bsel),
    .link(link), .speed(spd), .duplex(dup), .coll(col), .act(act),
    .led_clk(led_clk), .led_data(led_data));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] f, input logic nt);
    rst_n = 1'b0; fmt = f; ntest = nt;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic grab(output logic [3*NP-1:0] bits, output int n);
    int hi = 0;
    logic prev = 1'b1;
    bits = '1; n = 0;
    while (hi <= 2*CD) begin @(negedge clk); hi = led_clk ? hi + 1 : 0; end
    while (led_clk) @(negedge clk);
    hi = 0; prev = 1'b0;
    while (hi <= 2*CD) begin
      @(negedge clk);
      if (led_clk && !prev) begin
        if (n < 3*NP) bits[n] = led_data;
        n++;
      end
      prev = led_clk;
      hi = led_clk ? hi + 1 : 0;
    end
  endtask

  function automatic logic [3*NP-1:0] model(input logic [1:0] f, input logic [NP-1:0] l,
      input logic [NP-1:0] s, input logic [NP-1:0] d);
    logic [3*NP-1:0] v = '1;
    for (int p = 0; p < NP; p++) begin
      if (f == 2'b01) begin
        v[2*p] = ~s[p]; v[2*p+1] = ~l[p];
      end else begin
        v[3*p] = ~d[p];
        if (f == 2'b10) begin
          v[3*p+1] = ~(l[p] & ~s[p]); v[3*p+2] = ~(l[p] & s[p]);
        end else begin
          v[3*p+1] = ~l[p]; v[3*p+2] = ~s[p];
        end
      end
    end
    return v;
  endfunction

  typedef struct packed {
    logic [1:0] f; logic [NP-1:0] l; logic [NP-1:0] s; logic [NP-1:0] d; logic [7:0] nb;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{2'b00, 8'hFF, 8'h0F, 8'hA5, 8'd24},   // R2 R6
    '{2'b00, 8'h81, 8'hF0, 8'h3C, 8'd24},   // R2 R6
    '{2'b01, 8'h5A, 8'hC3, 8'h00, 8'd16},   // R3
    '{2'b01, 8'hFF, 8'h00, 8'hFF, 8'd16},   // R3
    '{2'b10, 8'hF3, 8'h55, 8'h0F, 8'd24},   // R4
    '{2'b11, 8'h6E, 8'h99, 8'hC1, 8'd24}    // R5
  };

  int wd = 0;
  logic wd_hit = 1'b0;
  always @(posedge clk) begin
    wd++;
    if (wd > 190000 && !wd_hit) begin
      wd_hit = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3*NP-1:0] b;
    int n;
    // R10
    repeat (3) @(negedge clk);
    check("R10 clk in reset", 32'(led_clk), 32'd1);
    check("R10 data in reset", 32'(led_data), 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) begin
      link = TBL[i].l; spd = TBL[i].s; dup = TBL[i].d; col = '0; act = '0;
      do_reset(TBL[i].f, 1'b1);
      grab(b, n);
      check($sformatf("R2/R3/R4/R5 length vec%0d", i), 32'(n), 32'(TBL[i].nb));
      check($sformatf("R2/R3/R4/R5/R6 bits vec%0d", i), 32'(b),
            32'(model(TBL[i].f, TBL[i].l, TBL[i].s, TBL[i].d)));
    end

    // R1: gap length, clock high throughout
    begin
      int hi = 0, mx = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        hi = led_clk ? hi + 1 : 0;
        if (hi > mx) mx = hi;
      end
      check("R1 gap high time", 32'(mx), 32'(GAP + CD));
    end

    // R8: strap changes after reset are ignored
    link = 8'hC5; spd = 8'h3A; dup = 8'h71;
    do_reset(2'b00, 1'b1);
    fmt = 2'b01; ntest = 1'b0;
    grab(b, n);
    check("R8 length after strap change", 32'(n), 32'd24);
    check("R8 bits after strap change", 32'(b), 32'(model(2'b00, link, spd, dup)));

    // R9: lamp test
    link = 8'hFF; spd = 8'hFF; dup = 8'hFF; bsel = 1'b1;
    do_reset(2'b00, 1'b0);
    begin
      int uni = 1, seen0 = 0, seen1 = 0;
      for (int k = 0; k < 15; k++) begin
        grab(b, n);
        if (b != '0 && b != '1) uni = 0;
        if (b == '0) seen0 = 1;
        if (b == '1) seen1 = 1;
      end
      check("R9 lamp frames uniform", 32'(uni), 32'd1);
      check("R9 lamp alternates", 32'(seen0 + seen1), 32'd2);
      repeat (TC) @(negedge clk);
      grab(b, n);
      check("R9 normal after lamp test", 32'(b), 32'(model(2'b00, link, spd, dup)));
    end

    // R7 / R6: blink rates via activity on port 3, collision on port 5
    link = 8'hFF; spd = '0; dup = '0; act = 8'h08; col = 8'h20;
    begin
      int tf = 0, ts = 0, tc = 0;
      logic pa, pc;
      bsel = 1'b1;
      do_reset(2'b00, 1'b1);
      grab(b, n); pa = b[10]; pc = b[15];
      for (int k = 0; k < 30; k++) begin
        grab(b, n);
        if (b[10] != pa) tf++;
        if (b[15] != pc) tc++;
        pa = b[10]; pc = b[15];
      end
      bsel = 1'b0;
      do_reset(2'b00, 1'b1);
      grab(b, n); pa = b[10];
      for (int k = 0; k < 30; k++) begin
        grab(b, n);
        if (b[10] != pa) ts++;
        pa = b[10];
      end
      check("R7 fast blink toggles", 32'(tf >= 7 && tf <= 12), 32'd1);
      check("R7 slow blink toggles", 32'(ts >= 2 && ts <= 5), 32'd1);
      check("R6 collision blinks", 32'(tc == tf), 32'd1);
      check("R6 steady bit port 0 link", 32'(b[1]), 32'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule